// File: doc/BRIEF.md
# Clock Select Register Bank with Staged Commit

This block is the register bank in front of a clock control unit. It stores the divider ratios and source selections that the dividers and glitch-free muxes further down the chip consume, and drives their current values out as three configuration words. Software reaches it over a simple word-addressed bus: a write strobe with address and data, and a combinational read path. Register n is at byte offset 4*(n-1), so the bus carries the word index n-1.

Every field reserves its most significant bit as a write-enable that is never stored. This lets software change one field with a single word write: it writes back the other fields exactly as read, and their enables read as 0. The immediate register drives its outputs on the next clock. The two staged registers write only shadow copies. Software loads those copies into the active outputs by writing 1 to a request register. The request bit stays set for a fixed number of cycles and then clears in the same cycle that both active words load together. Software polls the bit until it reads 0.

Top module: `clk_sel_bank`

## Requirements
- R1: Register n sits at word index n-1: the immediate register is register 1 (index 0), the staged registers are 9 and 10 (indices 8 and 9), and the request register is 11 (index 10). Every other index reads 0, and a write to it changes no output and no readable register.
- R2: A field changes on a bus write only when its top bit is 1 in the write data. Fields whose top bit is 0 keep their value. The immediate register holds these fields as [lsb:width]: [0:3], [3:5], [8:5], [13:5], [18:4], [22:6], [28:3]. Staged register 9 holds [0:7], [7:5], [12:4], [16:4], [20:4]. Staged register 10 holds [0:3], [3:4], [7:3].
- R3: A read returns only the stored value bits of a field. The top (enable) bit of every field and all bits outside fields read 0.
- R4: A write to the immediate register appears on `immCfg` in the cycle after the write edge.
- R5: A write to register 9 or 10 updates the shadow copy, which reads back at once. `activeCfgA` and `activeCfgB` do not change until a commit.
- R6: Writing data with bit 0 set to register 11 sets the request bit, which reads back as bit 0. Writing with bit 0 clear has no effect. A second request while one is pending neither restarts nor extends it.
- R7: Exactly COMMIT_DELAY cycles after the request edge, both active words load the shadow contents as they stood before that edge, and the request bit clears in that same cycle.
- R8: Shadow writes made while a request is pending are captured by that request's commit, provided they land before the commit edge.
- R9: After reset, the immediate word is IMM_RST, both shadow and active staged words are STGA_RST and STGB_RST, and the request bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W | Word index (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| immCfg | output | 32 | Immediate register field values |
| activeCfgA | output | 32 | Active (committed) copy of register 9 |
| activeCfgB | output | 32 | Active (committed) copy of register 10 |

## Verification
The bench builds the block with COMMIT_DELAY set to 5 and keeps the default address width and field layouts. The short delay puts many request windows into a few hundred random cycles. Random traffic then often makes shadow writes and repeated requests land inside a pending window, and sometimes on the commit edge itself. A reference model steps once per clock and uses a per-field (lsb, width) description, not masks, to predict every read and output word.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;

  localparam int DATA_W = 32;
  localparam int NUM_STAGED = 2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_IMM,
    RD_STGA,
    RD_STGB,
    RD_REQ
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  wrImm;
    logic [NUM_STAGED-1:0] wrStage;
    logic                  commit;
    rdSel_e                rdSel;
  } strobes_t;

  // Merge write data into a register under per-field top-bit enables.
  // weMask marks each field's top bit, valMask its stored value bits.
  // Scanning down from the MSB, the last enable bit seen governs the
  // value bits beneath it until a gap bit ends the field.
  function automatic logic [DATA_W-1:0] mergeFields(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] wd,
      input logic [DATA_W-1:0] weMask,
      input logic [DATA_W-1:0] valMask);
    logic en;
    logic [DATA_W-1:0] res;
    en  = 1'b0;
    res = cur;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      if (weMask[b]) en = wd[b];
      else if (!valMask[b]) en = 1'b0;
      if (valMask[b] && en) res[b] = wd[b];
    end
    return res & valMask;
  endfunction

endpackage

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
  import clk_sel_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int IMM_REG      = 1,
  parameter int STGA_REG     = 9,
  parameter int STGB_REG     = 10,
  parameter int REQ_REG      = 11,
  parameter int COMMIT_DELAY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              reqBit,
  output strobes_t          strobes,
  output logic              reqPending
);

  localparam int CNT_W = $clog2(COMMIT_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_DELAY - 1);
  localparam logic [ADDR_W-1:0] IMM_IDX  = ADDR_W'(IMM_REG - 1);
  localparam logic [ADDR_W-1:0] STGA_IDX = ADDR_W'(STGA_REG - 1);
  localparam logic [ADDR_W-1:0] STGB_IDX = ADDR_W'(STGB_REG - 1);
  localparam logic [ADDR_W-1:0] REQ_IDX  = ADDR_W'(REQ_REG - 1);

  logic [CNT_W-1:0] waitCnt;
  logic reqWrite;
  logic commitNow;

  assign reqWrite  = busWrite && (busAddr == REQ_IDX) && reqBit;
  assign commitNow = reqPending && (waitCnt == LAST);

  always_comb begin
    strobes.wrImm      = busWrite && (busAddr == IMM_IDX);
    strobes.wrStage[0] = busWrite && (busAddr == STGA_IDX);
    strobes.wrStage[1] = busWrite && (busAddr == STGB_IDX);
    strobes.commit     = commitNow;
    if (busAddr == IMM_IDX)       strobes.rdSel = RD_IMM;
    else if (busAddr == STGA_IDX) strobes.rdSel = RD_STGA;
    else if (busAddr == STGB_IDX) strobes.rdSel = RD_STGB;
    else if (busAddr == REQ_IDX)  strobes.rdSel = RD_REQ;
    else                          strobes.rdSel = RD_NONE;
  end

  // request window: set on a request write, clear on the commit edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPending <= 1'b0;
      waitCnt    <= '0;
    end else if (reqPending) begin
      if (commitNow) begin
        reqPending <= 1'b0;
        waitCnt    <= '0;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end else if (reqWrite) begin
      reqPending <= 1'b1;
      waitCnt    <= '0;
    end
  end

endmodule

// File: rtl/clk_sel_datapath.sv
module clk_sel_datapath
  import clk_sel_pkg::*;
#(
  parameter logic [DATA_W-1:0] IMM_WE   = 32'h4822_1084,
  parameter logic [DATA_W-1:0] IMM_VAL  = 32'h37DD_EF7B,
  parameter logic [DATA_W-1:0] IMM_RST  = 32'h0000_0001,
  parameter logic [DATA_W-1:0] STGA_WE  = 32'h0088_8840,
  parameter logic [DATA_W-1:0] STGA_VAL = 32'h0077_77BF,
  parameter logic [DATA_W-1:0] STGA_RST = 32'h0023_303F,
  parameter logic [DATA_W-1:0] STGB_WE  = 32'h0000_0244,
  parameter logic [DATA_W-1:0] STGB_VAL = 32'h0000_01BB,
  parameter logic [DATA_W-1:0] STGB_RST = 32'h0000_0009
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strobes_t                          strobes,
  input  logic                              reqPending,
  input  logic [DATA_W-1:0]                 busWdata,
  output logic [DATA_W-1:0]                 busRdata,
  output logic [DATA_W-1:0]                 immWord,
  output logic [NUM_STAGED-1:0][DATA_W-1:0] shadowWord,
  output logic [NUM_STAGED-1:0][DATA_W-1:0] activeWord
);

  localparam logic [NUM_STAGED-1:0][DATA_W-1:0] STG_WE  = {STGB_WE, STGA_WE};
  localparam logic [NUM_STAGED-1:0][DATA_W-1:0] STG_VAL = {STGB_VAL, STGA_VAL};
  localparam logic [NUM_STAGED-1:0][DATA_W-1:0] STG_RST = {STGB_RST, STGA_RST};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) immWord <= IMM_RST;
    else if (strobes.wrImm) immWord <= mergeFields(immWord, busWdata, IMM_WE, IMM_VAL);
  end

  for (genvar g = 0; g < NUM_STAGED; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shadowWord[g] <= STG_RST[g];
      else if (strobes.wrStage[g])
        shadowWord[g] <= mergeFields(shadowWord[g], busWdata, STG_WE[g], STG_VAL[g]);
    end

    // active copy takes the pre-edge shadow on the commit edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) activeWord[g] <= STG_RST[g];
      else if (strobes.commit) activeWord[g] <= shadowWord[g];
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_IMM:  busRdata = immWord;
      RD_STGA: busRdata = shadowWord[0];
      RD_STGB: busRdata = shadowWord[1];
      RD_REQ:  busRdata = {{(DATA_W-1){1'b0}}, reqPending};
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/clk_sel_bank.sv
module clk_sel_bank
  import clk_sel_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int COMMIT_DELAY = 8,
  parameter int IMM_REG      = 1,
  parameter int STGA_REG     = 9,
  parameter int STGB_REG     = 10,
  parameter int REQ_REG      = 11,
  parameter logic [31:0] IMM_WE   = 32'h4822_1084,
  parameter logic [31:0] IMM_VAL  = 32'h37DD_EF7B,
  parameter logic [31:0] IMM_RST  = 32'h0000_0001,
  parameter logic [31:0] STGA_WE  = 32'h0088_8840,
  parameter logic [31:0] STGA_VAL = 32'h0077_77BF,
  parameter logic [31:0] STGA_RST = 32'h0023_303F,
  parameter logic [31:0] STGB_WE  = 32'h0000_0244,
  parameter logic [31:0] STGB_VAL = 32'h0000_01BB,
  parameter logic [31:0] STGB_RST = 32'h0000_0009
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [31:0]       immCfg,
  output logic [31:0]       activeCfgA,
  output logic [31:0]       activeCfgB
);

  strobes_t strobes;
  logic reqPending;
  logic [NUM_STAGED-1:0][DATA_W-1:0] shadowWord;
  logic [NUM_STAGED-1:0][DATA_W-1:0] activeWord;
  logic [31:0] shadowA;
  logic [31:0] shadowB;

  clk_sel_ctrl #(
    .ADDR_W(ADDR_W), .IMM_REG(IMM_REG), .STGA_REG(STGA_REG),
    .STGB_REG(STGB_REG), .REQ_REG(REQ_REG), .COMMIT_DELAY(COMMIT_DELAY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .reqBit(busWdata[0]), .strobes(strobes), .reqPending(reqPending)
  );

  clk_sel_datapath #(
    .IMM_WE(IMM_WE), .IMM_VAL(IMM_VAL), .IMM_RST(IMM_RST),
    .STGA_WE(STGA_WE), .STGA_VAL(STGA_VAL), .STGA_RST(STGA_RST),
    .STGB_WE(STGB_WE), .STGB_VAL(STGB_VAL), .STGB_RST(STGB_RST)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqPending(reqPending),
    .busWdata(busWdata), .busRdata(busRdata), .immWord(immCfg),
    .shadowWord(shadowWord), .activeWord(activeWord)
  );

  assign shadowA    = shadowWord[0];
  assign shadowB    = shadowWord[1];
  assign activeCfgA = activeWord[0];
  assign activeCfgB = activeWord[1];

endmodule

// File: rtl/clk_sel_bank_checker.sv
module clk_sel_bank_checker #(
  parameter int ADDR_W       = 4,
  parameter int COMMIT_DELAY = 8,
  parameter int IMM_REG      = 1,
  parameter int REQ_REG      = 11,
  parameter logic [31:0] IMM_WE = 32'h4822_1084
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [31:0]       immCfg,
  input logic [31:0]       activeCfgA,
  input logic [31:0]       activeCfgB,
  input logic [31:0]       shadowA,
  input logic [31:0]       shadowB,
  input logic              reqPending
);

  localparam int HW = $clog2(COMMIT_DELAY + 2);
  localparam logic [ADDR_W-1:0] IMM_IDX = ADDR_W'(IMM_REG - 1);
  localparam logic [ADDR_W-1:0] REQ_IDX = ADDR_W'(REQ_REG - 1);

  logic [HW-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= '0;
    else if (reqPending) highCnt <= highCnt + 1'b1;
    else highCnt <= '0;
  end

  assert_commit_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqPending) |-> (activeCfgA == $past(shadowA) && activeCfgB == $past(shadowB)));

  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(reqPending) |-> ($stable(activeCfgA) && $stable(activeCfgB)));

  assert_we_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == IMM_IDX && (busWdata & IMM_WE) == 32'h0) |=> $stable(immCfg));

  assert_window_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    highCnt <= HW'(COMMIT_DELAY));

  assert_topbits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == IMM_IDX) |-> ((busRdata & IMM_WE) == 32'h0));

  assert_req_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == REQ_IDX && busWdata[0] && !reqPending) |=> reqPending);

endmodule

bind clk_sel_bank clk_sel_bank_checker #(
  .ADDR_W(ADDR_W), .COMMIT_DELAY(COMMIT_DELAY), .IMM_REG(IMM_REG),
  .REQ_REG(REQ_REG), .IMM_WE(IMM_WE)
) uChecker (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .immCfg(immCfg),
  .activeCfgA(activeCfgA), .activeCfgB(activeCfgB), .shadowA(shadowA),
  .shadowB(shadowB), .reqPending(reqPending)
);

// File: tb/clk_sel_bank_test.sv
`timescale 1ns/100ps
module clk_sel_bank_test;

  localparam int D = 5;
  localparam logic [31:0] IMM_RST  = 32'h0000_0001;
  localparam logic [31:0] STGA_RST = 32'h0023_303F;
  localparam logic [31:0] STGB_RST = 32'h0000_0009;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, immCfg, activeCfgA, activeCfgB;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  // reference state
  logic [31:0] mImm, mShA, mShB, mActA, mActB;
  logic mReq;
  int mCnt;
  // values sampled in the last cycle (pre-edge)
  logic [31:0] lastRd, lastImm, lastA, lastB;

  always #2 clk = ~clk;

  clk_sel_bank #(.COMMIT_DELAY(D)) uut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .immCfg(immCfg),
    .activeCfgA(activeCfgA), .activeCfgB(activeCfgB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // field description: lsb and width per register
  function automatic logic [31:0] modelMerge(input logic [31:0] cur, input logic [31:0] wd,
                                             input int which);
    int lsb[7];
    int wid[7];
    int n;
    logic [31:0] r;
    r = cur;
    case (which)
      0: begin
        n = 7;
        lsb = '{0, 3, 8, 13, 18, 22, 28};
        wid = '{3, 5, 5, 5, 4, 6, 3};
      end
      1: begin
        n = 5;
        lsb = '{0, 7, 12, 16, 20, 0, 0};
        wid = '{7, 5, 4, 4, 4, 0, 0};
      end
      default: begin
        n = 3;
        lsb = '{0, 3, 7, 0, 0, 0, 0};
        wid = '{3, 4, 3, 0, 0, 0, 0};
      end
    endcase
    for (int f = 0; f < n; f++) begin
      if (wd[lsb[f] + wid[f] - 1]) begin
        for (int i = 0; i < wid[f] - 1; i++) r[lsb[f] + i] = wd[lsb[f] + i];
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    case (a)
      4'd0:  return mImm;
      4'd8:  return mShA;
      4'd9:  return mShB;
      4'd10: return {31'b0, mReq};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelEdge(input logic wr, input logic [3:0] a, input logic [31:0] d);
    if (mReq) begin
      if (mCnt == D - 1) begin
        mActA = mShA; mActB = mShB; mReq = 1'b0; mCnt = 0;
      end else mCnt++;
    end else if (wr && a == 4'd10 && d[0]) begin
      mReq = 1'b1; mCnt = 0;
    end
    if (wr) begin
      case (a)
        4'd0: mImm = modelMerge(mImm, d, 0);
        4'd8: mShA = modelMerge(mShA, d, 1);
        4'd9: mShB = modelMerge(mShB, d, 2);
        default: ;
      endcase
    end
  endtask

  // one bus cycle: drive, compare pre-edge state with the model, clock, step model
  task automatic cycle(input logic wr, input logic [3:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    busWrite = wr; busAddr = a; busWdata = d;
    #1;
    lastRd = busRdata; lastImm = immCfg; lastA = activeCfgA; lastB = activeCfgB;
    check({tag, " R1 R3 read"}, busRdata, modelRead(a));
    check({tag, " R4 immCfg"}, immCfg, mImm);
    check({tag, " R5 activeCfgA"}, activeCfgA, mActA);
    check({tag, " R5 activeCfgB"}, activeCfgB, mActB);
    @(posedge clk);
    modelEdge(wr, a, d);
  endtask

  initial begin
    #(4 * 200000);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    mImm = IMM_RST; mShA = STGA_RST; mShB = STGB_RST;
    mActA = STGA_RST; mActB = STGB_RST; mReq = 1'b0; mCnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R9 reset state
    cycle(0, 4'd10, 0, "reset");
    check("R9 req after reset", lastRd, 32'h0);
    check("R9 imm after reset", lastImm, IMM_RST);
    check("R9 activeA after reset", lastA, STGA_RST);
    check("R9 activeB after reset", lastB, STGB_RST);
    cycle(0, 4'd8, 0, "reset");
    check("R9 shadowA after reset", lastRd, STGA_RST);

    // R2/R4: only fields with top bit set change
    cycle(1, 4'd0, 32'h0000_0087, "imm wr");
    cycle(0, 4'd0, 0, "imm rd");
    check("R4 imm updated", lastImm, 32'h0000_0003);
    check("R3 imm readback", lastRd, 32'h0000_0003);
    cycle(1, 4'd0, 32'h37DD_EF7B, "imm nowe");
    cycle(0, 4'd0, 0, "imm rd");
    check("R2 no enable no change", lastImm, 32'h0000_0003);

    // R1 unmapped write ignored, reads 0
    cycle(1, 4'd5, 32'hFFFF_FFFF, "unmapped");
    cycle(0, 4'd5, 0, "unmapped rd");
    check("R1 unmapped reads zero", lastRd, 32'h0);
    check("R1 imm untouched", lastImm, 32'h0000_0003);

    // R5 shadow write does not reach active
    cycle(1, 4'd8, 32'h00D0_0000, "stgA wr");
    cycle(0, 4'd8, 0, "stgA rd");
    check("R5 shadowA readback", lastRd, 32'h0053_303F);
    check("R5 activeA held", lastA, STGA_RST);

    // R6 writing 0 to request has no effect
    cycle(1, 4'd10, 32'hFFFF_FFFE, "req0");
    cycle(0, 4'd10, 0, "req rd");
    check("R6 req write zero ignored", lastRd, 32'h0);

    // R6/R7/R8 request, shadow write during window, commit timing
    cycle(1, 4'd10, 32'h1, "req1");
    cycle(1, 4'd9, 32'h0000_0380, "stgB pend");
    for (int i = 0; i < D - 2; i++) cycle(0, 4'd10, 0, "wait");
    cycle(0, 4'd10, 0, "precommit");
    check("R6 req still set", lastRd, 32'h1);
    check("R7 activeA before commit", lastA, STGA_RST);
    cycle(0, 4'd10, 0, "postcommit");
    check("R7 req cleared", lastRd, 32'h0);
    check("R7 activeA committed", lastA, 32'h0053_303F);
    check("R8 activeB committed", lastB, 32'h0000_0189);

    // R6 second request while pending does not restart
    cycle(1, 4'd10, 32'h1, "req2");
    cycle(0, 4'd10, 0, "wait");
    cycle(1, 4'd10, 32'h1, "req again");
    for (int i = 0; i < D - 3; i++) cycle(0, 4'd10, 0, "wait");
    cycle(0, 4'd10, 0, "restart chk");
    check("R6 pending at window end", lastRd, 32'h1);
    cycle(0, 4'd10, 0, "restart chk2");
    check("R6 no restart, cleared", lastRd, 32'h0);

    // random traffic
    void'($urandom(32'd4242));
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1:    a = 4'd0;
        2, 3, 4: a = 4'd8;
        5, 6:    a = 4'd9;
        7:       a = 4'd10;
        default: a = 4'($urandom_range(0, 15));
      endcase
      d = $urandom;
      cycle(1'($urandom_range(0, 1)), a, d, "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule